// File: doc/BRIEF.md
# Bus Access Match Comparators

This block watches every access cycle on a CPU bus and raises a one-cycle match pulse whenever an access fits one of three programmed patterns. Each cycle it samples the address, the 16-bit data word, the direction (read or write) and the size (byte or word). A separate debug sequencer consumes the three match pulses and decides what each one means.

There are three comparator lanes. Lane A compares the address and the data word, and only the data bits selected by a care mask take part. Lanes B and C compare the address alone. Lane B can also be restricted to byte or word accesses. Any lane can be restricted to reads or to writes. In the two range modes, lanes A and B work as a pair. A's reference is the lower bound and B's reference is the upper bound, and the result is reported on A's output. Software programs all of this through a small write-only register port.

Top module: `bus_match_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, all three match outputs are 0. Every configuration register clears to 0, so all lanes start disabled.
- R2: In simple mode (mode field 00 or 11), a lane's match output is 1 in the cycle after a qualified access whose address equals that lane's reference address. Otherwise the output is 0, so a single matching access gives a single-cycle pulse.
- R3: Lane A also requires `(bus_data ^ ref_data) & care_mask == 0`. A care-mask bit of 1 makes that data bit take part. A bit of 0 ignores it.
- R4: Each lane's direction field, bits [2:1] of its control register, selects the accesses it accepts. 01 accepts reads only (`bus_rnw`=1). 10 accepts writes only. 00 and 11 accept both.
- R5: Lane B's size field, bits [4:3] of its control register, selects the accesses it accepts. 01 accepts byte accesses only (`bus_byte`=1). 10 accepts word accesses only. 00 and 11 accept both. Lanes A and C ignore these bits.
- R6: Bit 0 of a lane's control register enables the lane. A lane whose bit is 0 never drives its match output high.
- R7: A cycle with `bus_valid`=0 (a free cycle) produces no match on any output, whatever the address and data.
- R8: In inside-range mode (mode field 01), `match_a` is 1 in the cycle after an access that passes lane A's enable, direction and data qualifiers and whose address satisfies ref_A ≤ address ≤ ref_B. Both bounds are inclusive.
- R9: In outside-range mode (mode field 10), `match_a` is 1 in the cycle after an access that passes lane A's qualifiers and whose address satisfies address < ref_A or address > ref_B.
- R10: In either range mode, `match_b` stays 0, and lane B's enable, direction and size bits have no effect. Lane C still works as in simple mode.
- R11: Writes with `cfg_we`=1 load the register selected by `cfg_sel` at the clock edge. The selections are:
  - 0: A address
  - 1: A data
  - 2: A care mask
  - 3: B address
  - 4: C address
  - 5: A control
  - 6: B control
  - 7: C control
  - 8: mode, in bits [1:0]

  Other selections are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| bus_valid | input | 1 | 1 = access cycle, 0 = free cycle |
| bus_addr | input | 16 | Access address |
| bus_data | input | 16 | Access data word |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| match_a | output | 1 | Lane A match pulse, or range match in the range modes |
| match_b | output | 1 | Lane B match pulse, 0 in the range modes |
| match_c | output | 1 | Lane C match pulse |

## Verification
Lane A is driven with exact address and data hits, with data that differs in a masked bit, and with data that differs in a cared-for bit. This separates the mask logic from a plain equality test. Direction and size qualifiers are tried with both the accepted and the rejected access type, along with disabled lanes and free cycles that carry a matching address. These show that each qualifier gates the match on its own. The range modes are probed at min−1, min, max and max+1, which exposes off-by-one and inverted-bound errors. A back-to-back hit followed by a miss confirms single-cycle pulses.

// File: rtl/bmu_pkg.sv
// Package: shared types and register select codes for the bus match unit.
package bmu_pkg;

    // Operating mode of the comparator pair A/B.
    typedef enum logic [1:0] {
        MODE_SIMPLE   = 2'b00,
        MODE_INSIDE   = 2'b01,
        MODE_OUTSIDE  = 2'b10,
        MODE_SIMPLE_X = 2'b11
    } cmp_mode_e;

    // Per-lane control word: size qualifier, direction qualifier, enable.
    typedef struct packed {
        logic [1:0] size_q;
        logic [1:0] dir_q;
        logic       en;
    } lane_ctl_t;

    localparam int CTL_W = $bits(lane_ctl_t);

    // Configuration register select codes.
    localparam logic [3:0] SEL_A_ADDR = 4'd0;
    localparam logic [3:0] SEL_A_DATA = 4'd1;
    localparam logic [3:0] SEL_A_MASK = 4'd2;
    localparam logic [3:0] SEL_B_ADDR = 4'd3;
    localparam logic [3:0] SEL_C_ADDR = 4'd4;
    localparam logic [3:0] SEL_A_CTL  = 4'd5;
    localparam logic [3:0] SEL_B_CTL  = 4'd6;
    localparam logic [3:0] SEL_C_CTL  = 4'd7;
    localparam logic [3:0] SEL_MODE   = 4'd8;

endpackage

// File: rtl/bmu_regs.sv
// Module: bmu_regs
// Holds the comparator configuration: reference addresses, lane A data and
// care mask, per-lane control words and the pair mode.
// Assumes: single write port, ADDR_W and DATA_W not wider than CFG_W.
module bmu_regs
    import bmu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [3:0]             cfg_sel,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [2:0][ADDR_W-1:0] ref_addr,
    output logic [DATA_W-1:0]      ref_data,
    output logic [DATA_W-1:0]      care_mask,
    output lane_ctl_t [2:0]        lane_ctl,
    output cmp_mode_e              mode
);

    // Load the selected register on a write strobe; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_addr  <= '0;
            ref_data  <= '0;
            care_mask <= '0;
            lane_ctl  <= '0;
            mode      <= MODE_SIMPLE;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_A_ADDR: ref_addr[0] <= cfg_wdata[ADDR_W-1:0];
                SEL_B_ADDR: ref_addr[1] <= cfg_wdata[ADDR_W-1:0];
                SEL_C_ADDR: ref_addr[2] <= cfg_wdata[ADDR_W-1:0];
                SEL_A_DATA: ref_data    <= cfg_wdata[DATA_W-1:0];
                SEL_A_MASK: care_mask   <= cfg_wdata[DATA_W-1:0];
                SEL_A_CTL:  lane_ctl[0] <= lane_ctl_t'(cfg_wdata[CTL_W-1:0]);
                SEL_B_CTL:  lane_ctl[1] <= lane_ctl_t'(cfg_wdata[CTL_W-1:0]);
                SEL_C_CTL:  lane_ctl[2] <= lane_ctl_t'(cfg_wdata[CTL_W-1:0]);
                SEL_MODE:   mode        <= cmp_mode_e'(cfg_wdata[1:0]);
                default: ;
            endcase
        end
    end

    logic unused_cfg;
    assign unused_cfg = ^cfg_wdata;

endmodule

// File: rtl/bmu_lane.sv
// Module: bmu_lane
// One comparator lane. Produces address relations against the lane's
// reference and a qualifier flag (valid, enable, direction, optional size,
// optional masked data). Purely combinational; the top registers results.
// Assumes: HAS_DATA / HAS_SIZE choose the variant at elaboration.
module bmu_lane
    import bmu_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter bit HAS_DATA = 1'b0,
    parameter bit HAS_SIZE = 1'b0
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] care_mask,
    input  lane_ctl_t         ctl,
    output logic              addr_eq,
    output logic              addr_lt,
    output logic              addr_gt,
    output logic              qual_ok
);

    logic dir_ok;
    logic size_ok;
    logic data_ok;

    // Address relations of the bus address against the reference.
    always_comb begin
        addr_eq = (bus_addr == ref_addr);
        addr_lt = (bus_addr <  ref_addr);
        addr_gt = (bus_addr >  ref_addr);
    end

    // Direction qualifier: 01 reads only, 10 writes only, else either.
    always_comb begin
        case (ctl.dir_q)
            2'b01:   dir_ok = bus_rnw;
            2'b10:   dir_ok = !bus_rnw;
            default: dir_ok = 1'b1;
        endcase
    end

    generate
        if (HAS_SIZE) begin : g_size
            // Size qualifier: 01 byte only, 10 word only, else either.
            always_comb begin
                case (ctl.size_q)
                    2'b01:   size_ok = bus_byte;
                    2'b10:   size_ok = !bus_byte;
                    default: size_ok = 1'b1;
                endcase
            end
        end else begin : g_nosize
            logic unused_size;
            assign unused_size = bus_byte ^ (^ctl.size_q);
            assign size_ok = 1'b1;
        end

        if (HAS_DATA) begin : g_data
            // Masked data compare: only cared-for bits must agree.
            assign data_ok = ~|((bus_data ^ ref_data) & care_mask);
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{bus_data, ref_data, care_mask};
            assign data_ok = 1'b1;
        end
    endgenerate

    // Combine all qualifiers into one lane flag.
    assign qual_ok = bus_valid & ctl.en & dir_ok & size_ok & data_ok;

endmodule

// File: rtl/bus_match_unit.sv
// Module: bus_match_unit
// Top: three comparator lanes on a CPU bus. Lane A (address + masked data),
// lane B (address, size qualifier), lane C (address). In range modes A and B
// form a [min,max] pair reported on match_a. Matches are registered and
// appear one cycle after the access.
// Assumes: one access per cycle, bus_valid low on free cycles.
module bus_match_unit
    import bmu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_we,
    input  logic [3:0]                                 cfg_sel,
    input  logic [((ADDR_W > DATA_W) ? ADDR_W : DATA_W)-1:0] cfg_wdata,
    input  logic                                       bus_valid,
    input  logic [ADDR_W-1:0]                          bus_addr,
    input  logic [DATA_W-1:0]                          bus_data,
    input  logic                                       bus_rnw,
    input  logic                                       bus_byte,
    output logic                                       match_a,
    output logic                                       match_b,
    output logic                                       match_c
);

    localparam int CFG_W   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int N_LANES = 3;

    logic [2:0][ADDR_W-1:0] ref_addr;
    logic [DATA_W-1:0]      ref_data;
    logic [DATA_W-1:0]      care_mask;
    lane_ctl_t [2:0]        lane_ctl;
    cmp_mode_e              mode;

    logic [N_LANES-1:0] eq, lt, gt, qual;
    logic nxt_a, nxt_b, nxt_c;
    logic in_range_mode;

    bmu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ref_addr  (ref_addr),
        .ref_data  (ref_data),
        .care_mask (care_mask),
        .lane_ctl  (lane_ctl),
        .mode      (mode)
    );

    generate
        for (genvar i = 0; i < N_LANES; i++) begin : g_lane
            bmu_lane #(
                .ADDR_W   (ADDR_W),
                .DATA_W   (DATA_W),
                .HAS_DATA (i == 0),
                .HAS_SIZE (i == 1)
            ) u_lane (
                .bus_valid (bus_valid),
                .bus_addr  (bus_addr),
                .bus_data  (bus_data),
                .bus_rnw   (bus_rnw),
                .bus_byte  (bus_byte),
                .ref_addr  (ref_addr[i]),
                .ref_data  (ref_data),
                .care_mask (care_mask),
                .ctl       (lane_ctl[i]),
                .addr_eq   (eq[i]),
                .addr_lt   (lt[i]),
                .addr_gt   (gt[i]),
                .qual_ok   (qual[i])
            );
        end
    endgenerate

    logic unused_rel;
    assign unused_rel = lt[1] ^ lt[2] ^ gt[0] ^ gt[2];

    assign in_range_mode = (mode == MODE_INSIDE) || (mode == MODE_OUTSIDE);

    // Select the next match values according to the pair mode.
    always_comb begin
        case (mode)
            MODE_INSIDE:  nxt_a = qual[0] & !lt[0] & !gt[1];
            MODE_OUTSIDE: nxt_a = qual[0] & (lt[0] | gt[1]);
            default:      nxt_a = qual[0] & eq[0];
        endcase
        nxt_b = !in_range_mode & qual[1] & eq[1];
        nxt_c = qual[2] & eq[2];
    end

    // Register match pulses one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_a <= 1'b0;
            match_b <= 1'b0;
            match_c <= 1'b0;
        end else begin
            match_a <= nxt_a;
            match_b <= nxt_b;
            match_c <= nxt_c;
        end
    end

    // R7
    free_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid) |-> !(match_a | match_b | match_c));

    // R10
    range_b_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_range_mode) |-> !match_b);

    // R6
    disabled_c_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!lane_ctl[2].en) |-> !match_c);

    // R4
    c_dir_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lane_ctl[2].dir_q == 2'b01 && !bus_rnw) |-> !match_c);

    // R2
    c_addr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> $past(bus_addr == ref_addr[2]));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !(match_a | match_b | match_c));

endmodule

// File: tb/sim_bus_match_unit.sv
module sim_bus_match_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_rnw = 1'b0;
    logic        bus_byte = 1'b0;
    logic        match_a, match_b, match_c;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bus_match_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_rnw(bus_rnw), .bus_byte(bus_byte),
        .match_a(match_a), .match_b(match_b), .match_c(match_c)
    );

    // Bench-side copy of what was programmed (from the register map, R11).
    logic [15:0] m_addr [3];
    logic [15:0] m_data, m_mask;
    logic [4:0]  m_ctl [3];
    logic [1:0]  m_mode;

    logic [2:0] q_exp [$];
    string      q_tag [$];

    function automatic logic dir_pass(input logic [1:0] d, input logic rnw);
        if (d == 2'b01) return rnw;
        if (d == 2'b10) return !rnw;
        return 1'b1;
    endfunction

    function automatic logic size_pass(input logic [1:0] s, input logic byt);
        if (s == 2'b01) return byt;
        if (s == 2'b10) return !byt;
        return 1'b1;
    endfunction

    // Expected {c,b,a} from the requirements.
    function automatic logic [2:0] expect_of(input logic v, input logic [15:0] a,
            input logic [15:0] d, input logic rnw, input logic byt);
        logic qa, qb, qc, ea, eb, ec;
        qa = v && m_ctl[0][0] && dir_pass(m_ctl[0][2:1], rnw)
               && (((d ^ m_data) & m_mask) == 16'h0);
        qb = v && m_ctl[1][0] && dir_pass(m_ctl[1][2:1], rnw)
               && size_pass(m_ctl[1][4:3], byt);
        qc = v && m_ctl[2][0] && dir_pass(m_ctl[2][2:1], rnw);
        if (m_mode == 2'b01) begin
            ea = qa && (a >= m_addr[0]) && (a <= m_addr[1]);
            eb = 1'b0;
        end else if (m_mode == 2'b10) begin
            ea = qa && ((a < m_addr[0]) || (a > m_addr[1]));
            eb = 1'b0;
        end else begin
            ea = qa && (a == m_addr[0]);
            eb = qb && (a == m_addr[1]);
        end
        ec = qc && (a == m_addr[2]);
        return {ec, eb, ea};
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        case (sel)
            4'd0: m_addr[0] = val;
            4'd1: m_data = val;
            4'd2: m_mask = val;
            4'd3: m_addr[1] = val;
            4'd4: m_addr[2] = val;
            4'd5: m_ctl[0] = val[4:0];
            4'd6: m_ctl[1] = val[4:0];
            4'd7: m_ctl[2] = val[4:0];
            4'd8: m_mode = val[1:0];
            default: ;
        endcase
        @(posedge clk); #1 cfg_we = 1'b0;
    endtask

    // Driver: one bus cycle, expected result pushed to the scoreboard.
    task automatic acc(input logic v, input logic [15:0] a, input logic [15:0] d,
            input logic rnw, input logic byt, input string tag);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d; bus_rnw = rnw; bus_byte = byt;
        q_exp.push_back(expect_of(v, a, d, rnw, byt));
        q_tag.push_back(tag);
        @(posedge clk); #1 bus_valid = 1'b0;
    endtask

    // Monitor: compare outputs registered at this edge with the queue head.
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            logic [2:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({match_c, match_b, match_a} !== e) begin
                failures++;
                $display("FAIL %s: {c,b,a} actual=%b expected=%b", t,
                         {match_c, match_b, match_a}, e);
            end
        end
    end

    initial begin
        #(20 * 20000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_addr[i] = '0; m_ctl[i] = '0; end
        m_data = '0; m_mask = '0; m_mode = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs low during reset
        checks++;
        if ({match_c, match_b, match_a} !== 3'b000) begin
            failures++;
            $display("FAIL R1: actual=%b expected=000", {match_c, match_b, match_a});
        end
        @(negedge clk); rst_n = 1'b1;
        // R1/R6: config cleared, lanes disabled, address 0 matches nothing
        acc(1, 16'h0000, 16'h0000, 1, 0, "R1 cleared config");

        // R2/R3/R11: lane A simple match with masked data
        wr(4'd0, 16'h1234); wr(4'd1, 16'hABCD); wr(4'd2, 16'hFF00);
        wr(4'd5, 16'h0001);
        acc(1, 16'h1234, 16'hABCD, 1, 0, "R2 A exact hit");
        acc(1, 16'h1234, 16'hAB00, 0, 0, "R3 masked bits differ");
        acc(1, 16'h1234, 16'hAACD, 1, 0, "R3 cared bit differs");
        acc(1, 16'h1235, 16'hABCD, 1, 0, "R2 A address miss");
        // R2: pulse then miss
        acc(1, 16'h1234, 16'hABCD, 1, 0, "R2 back to back 1");
        acc(1, 16'h1234, 16'hABCD, 1, 0, "R2 back to back 2");
        acc(1, 16'h0000, 16'hABCD, 1, 0, "R2 pulse ends");
        // R4: A reads only, then writes only
        wr(4'd5, 16'h0003);
        acc(1, 16'h1234, 16'hABCD, 0, 0, "R4 A read-only rejects write");
        acc(1, 16'h1234, 16'hABCD, 1, 0, "R4 A read-only accepts read");
        wr(4'd5, 16'h0005);
        acc(1, 16'h1234, 16'hABCD, 1, 0, "R4 A write-only rejects read");
        acc(1, 16'h1234, 16'hABCD, 0, 0, "R4 A write-only accepts write");

        // R5: lane B byte only, then word only
        wr(4'd3, 16'h2000); wr(4'd6, 16'h0009);
        acc(1, 16'h2000, 16'h0, 1, 0, "R5 B byte-only rejects word");
        acc(1, 16'h2000, 16'h0, 1, 1, "R5 B byte-only accepts byte");
        wr(4'd6, 16'h0011);
        acc(1, 16'h2000, 16'h0, 0, 1, "R5 B word-only rejects byte");
        acc(1, 16'h2000, 16'h0, 0, 0, "R5 B word-only accepts word");

        // R6: lane C enabled, then disabled
        wr(4'd4, 16'h3000); wr(4'd7, 16'h0001);
        acc(1, 16'h3000, 16'h0, 1, 0, "R6 C enabled hit");
        wr(4'd7, 16'h0000);
        acc(1, 16'h3000, 16'h0, 1, 0, "R6 C disabled no hit");
        wr(4'd7, 16'h0001);

        // R7: free cycle with matching address and data
        acc(0, 16'h3000, 16'h0, 1, 0, "R7 free cycle C");
        wr(4'd5, 16'h0001);
        acc(0, 16'h1234, 16'hABCD, 1, 0, "R7 free cycle A");

        // R8: inside range [0x1234, 0x2000], data mask cleared
        wr(4'd2, 16'h0000); wr(4'd6, 16'h0001); wr(4'd8, 16'h0001);
        acc(1, 16'h1233, 16'h0, 1, 0, "R8 below min");
        acc(1, 16'h1234, 16'h0, 1, 0, "R8 at min");
        acc(1, 16'h2000, 16'h0, 1, 1, "R8 at max, R10 B silent");
        acc(1, 16'h2001, 16'h0, 1, 0, "R8 above max");
        acc(1, 16'h3000, 16'h0, 1, 0, "R10 C works in range mode");

        // R9: outside range
        wr(4'd8, 16'h0002);
        acc(1, 16'h1233, 16'h0, 1, 0, "R9 below min");
        acc(1, 16'h1234, 16'h0, 1, 0, "R9 at min");
        acc(1, 16'h2000, 16'h0, 1, 0, "R9 at max, R10 B silent");
        acc(1, 16'h2001, 16'h0, 1, 0, "R9 above max");

        // R2: mode 11 behaves as simple; R11 unused select ignored
        wr(4'd8, 16'h0003);
        wr(4'd12, 16'hFFFF);
        acc(1, 16'h2000, 16'h0, 1, 0, "R2 mode 11 B hit, R11 sel 12 ignored");
        acc(1, 16'h1234, 16'h0, 1, 0, "R2 mode 11 A hit");

        repeat (3) @(posedge clk);
        #5;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule